// File: doc/BRIEF.md
# Transmit FIFO Flush Controller

This block is the flush control register for a transmit path that holds several FIFOs. Software selects a FIFO by writing a five-bit selector together with a request bit. The block then waits until the chosen FIFO is no longer being read or written, so that a flush never cuts a transaction in half. It then sends a one-cycle clear pulse to that FIFO's pointers and clears the request bit by itself. One selector code reaches every transmit FIFO at once. A second request bit does the same job for the receive FIFO.

The same 32-bit register also reports two status lines. One shows that the bus master state machine is idle, and the other shows that a DMA request is outstanding. Software polls the request bit to learn when the flush has finished. While a request is pending, the selector field is locked, so the flush cannot change target partway through.

Top module: `fifo_flush_ctrl`

## Requirements
- R1: While `rst` is high, `reg_rdata` holds 32'h8000_0000, whatever the status inputs are.
- R2: `reg_rdata[31]` shows `master_idle` and `reg_rdata[30]` shows `dma_req`, each one clock after the input is sampled.
- R3: `reg_rdata` bits 29:11 and 3:0 always read 0, even after a write of all ones.
- R4: A write with bit 5 (transmit request) or bit 4 (receive request) at 1 sets that request bit. A write with the bit at 0 leaves it unchanged and causes no flush.
- R5: In device mode (`host_mode`=0), selector values 0 to 15 in bits 10:6 pulse only `tx_flush[sel]`, and the pulse lasts exactly one cycle.
- R6: Selector 5'b10000 pulses every bit of `tx_flush` in the same cycle.
- R7: In host mode, selector 0 (non-periodic FIFO) pulses `tx_flush[0]` and selector 1 (periodic FIFO) pulses `tx_flush[1]`. Selectors 2 to 15 pulse nothing.
- R8: While any selected FIFO has its `tx_busy` bit high, no pulse is issued. The pulse comes in the first cycle after those busy bits go low. With 5'b10000, every busy bit must be low. Busy bits of FIFOs that are not selected do not delay the flush.
- R9: While the transmit request bit is 1, writes to bits 10:6 are ignored.
- R10: The transmit request bit reads 0 from the cycle after the clear pulse.
- R11: A selector above 15 other than 5'b10000 produces no pulse, and the request bit still clears.
- R12: The receive request waits for `rx_busy` to be low, then drives a one-cycle `rx_flush` pulse, then clears bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_mode | input | 1 | 1 = host selector mapping, 0 = device mapping |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| master_idle | input | 1 | Bus master state machine is idle |
| dma_req | input | 1 | DMA request outstanding |
| tx_busy | input | 16 | Per transmit FIFO: a transaction is in progress |
| rx_busy | input | 1 | Receive FIFO transaction in progress |
| tx_flush | output | 16 | Per transmit FIFO: one-cycle pointer clear |
| rx_flush | output | 1 | One-cycle receive FIFO pointer clear |

## Verification
The bench drives its inputs on the falling edge, so a write is captured on the next rising edge, E0. With no busy FIFO selected, the clear pulse is visible after edge E1 and drops after E2. `reg_rdata` is registered, so it lags the internal state by one edge: the request bit still reads 1 after E2 and reads 0 after E3. Each scenario task counts these edges from its own write or busy release and samples on the falling edge at exactly those points. A deferred flush is timed from the release of the busy input, not from the write.

// File: rtl/flush_pkg.sv
package flush_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = 5;
  localparam int unsigned BIT_IDLE = 31;
  localparam int unsigned BIT_DMA  = 30;
  localparam int unsigned SEL_LO   = 6;
  localparam int unsigned SEL_HI   = SEL_LO + SEL_W - 1;
  localparam int unsigned BIT_TXRQ = 5;
  localparam int unsigned BIT_RXRQ = 4;
  localparam logic [SEL_W-1:0] SEL_ALL = 5'b10000;
  localparam int unsigned HOST_FIFOS = 2;
  localparam logic [DATA_W-1:0] RST_VAL = 32'h8000_0000;

  typedef enum logic {SQ_ARM, SQ_PULSE} sq_state_t;
endpackage

// File: rtl/flush_sel_decode.sv
module flush_sel_decode
  import flush_pkg::*;
#(
  parameter int unsigned NUM_TX = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              host_mode,
  output logic [NUM_TX-1:0] mask
);
  logic all_hit;
  assign all_hit = (sel == SEL_ALL);

  for (genvar i = 0; i < NUM_TX; i++) begin : g_lane
    localparam bit HOST_OK = (i < HOST_FIFOS);
    logic idx_hit;
    assign idx_hit = (sel == SEL_W'(i));
    assign mask[i] = all_hit | (idx_hit & (~host_mode | HOST_OK));
  end

  always_comb begin
    if (!host_mode && sel < SEL_W'(NUM_TX))
      AST_SINGLE_LANE: assert ($countones(mask) == 1); // R5
  end
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] busy,
  output logic [W-1:0] pulse,
  output logic         done
);
  sq_state_t state;
  logic      clear_ok;

  assign clear_ok = ((busy & mask) == '0);
  assign done     = (state == SQ_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_ARM;
      pulse <= '0;
    end else begin
      case (state)
        SQ_ARM: begin
          if (req && clear_ok) begin
            state <= SQ_PULSE;
            pulse <= mask;
          end
        end
        default: begin
          state <= SQ_ARM;
          pulse <= '0;
        end
      endcase
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pulse != '0) |=> (pulse == '0)); // R5

  AST_NO_FLUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pulse != '0) |-> (($past(busy) & pulse) == '0)); // R8

  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(req)); // R4
endmodule

// File: rtl/flush_csr.sv
module flush_csr
  import flush_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              master_idle,
  input  logic              dma_req,
  input  logic              tx_done,
  input  logic              rx_done,
  output logic [SEL_W-1:0]  sel,
  output logic              tx_req,
  output logic              rx_req,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:SEL_HI+1], wdata[BIT_RXRQ-1:0]};

  logic tx_set, rx_set;
  assign tx_set = wr & wdata[BIT_TXRQ];
  assign rx_set = wr & wdata[BIT_RXRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      if (wr && !tx_req)
        sel <= wdata[SEL_HI:SEL_LO];
      if (tx_set)
        tx_req <= 1'b1;
      else if (tx_done)
        tx_req <= 1'b0;
      if (rx_set)
        rx_req <= 1'b1;
      else if (rx_done)
        rx_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= RST_VAL;
    end else begin
      rdata                <= '0;
      rdata[BIT_IDLE]      <= master_idle;
      rdata[BIT_DMA]       <= dma_req;
      rdata[SEL_HI:SEL_LO] <= sel;
      rdata[BIT_TXRQ]      <= tx_req;
      rdata[BIT_RXRQ]      <= rx_req;
    end
  end

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> $stable(sel)); // R9

  AST_TX_CLEAR_BY_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_req) |-> $past(tx_done)); // R10

  AST_RX_CLEAR_BY_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_req) |-> $past(rx_done)); // R12

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata[BIT_DMA-1:SEL_HI+1] == '0) && (rdata[BIT_RXRQ-1:0] == '0)); // R3
endmodule

// File: rtl/fifo_flush_ctrl.sv
module fifo_flush_ctrl
  import flush_pkg::*;
#(
  parameter int unsigned NUM_TX = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              master_idle,
  input  logic              dma_req,
  input  logic [NUM_TX-1:0] tx_busy,
  input  logic              rx_busy,
  output logic [NUM_TX-1:0] tx_flush,
  output logic              rx_flush
);
  logic [SEL_W-1:0]  sel;
  logic              tx_req, rx_req, tx_done, rx_done;
  logic [NUM_TX-1:0] tx_mask;

  flush_csr u_csr (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .master_idle(master_idle), .dma_req(dma_req),
    .tx_done(tx_done), .rx_done(rx_done),
    .sel(sel), .tx_req(tx_req), .rx_req(rx_req), .rdata(reg_rdata)
  );

  flush_sel_decode #(.NUM_TX(NUM_TX)) u_dec (
    .sel(sel), .host_mode(host_mode), .mask(tx_mask)
  );

  flush_seq #(.W(NUM_TX)) u_txseq (
    .clk(clk), .rst(rst), .req(tx_req), .mask(tx_mask),
    .busy(tx_busy), .pulse(tx_flush), .done(tx_done)
  );

  flush_seq #(.W(1)) u_rxseq (
    .clk(clk), .rst(rst), .req(rx_req), .mask(1'b1),
    .busy(rx_busy), .pulse(rx_flush), .done(rx_done)
  );

  AST_ALL_CODE_WHOLE: assert property (@(posedge clk) disable iff (rst)
    (tx_flush != '0 && $past(sel) == SEL_ALL) |-> (&tx_flush)); // R6

  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) > SEL_ALL) |-> (tx_flush == '0)); // R11

  AST_RESET_VALUE: assert property (@(posedge clk)
    $past(rst) |-> (reg_rdata == RST_VAL)); // R1
endmodule

// File: tb/fifo_flush_ctrl_tb.sv
module fifo_flush_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        host_mode = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        master_idle = 0;
  logic        dma_req = 0;
  logic [15:0] tx_busy = '0;
  logic        rx_busy = 0;
  logic [15:0] tx_flush;
  logic        rx_flush;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fifo_flush_ctrl u_dut (
    .clk(clk), .rst(rst), .host_mode(host_mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_idle(master_idle),
    .dma_req(dma_req), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .tx_flush(tx_flush), .rx_flush(rx_flush)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [31:0] d);
    reg_wr = 1;
    reg_wdata = d;
    tick();
    reg_wr = 0;
    reg_wdata = '0;
  endtask

  function automatic logic [31:0] txcmd(input logic [4:0] s);
    return (32'(s) << 6) | 32'h20;
  endfunction

  task automatic t_reset();
    rst = 1;
    master_idle = 0;
    dma_req = 1;
    tick(); tick();
    chk(reg_rdata == 32'h8000_0000, "R1 reset value", reg_rdata, 32'h8000_0000);
    chk(tx_flush == 0 && rx_flush == 0, "R1 no pulse in reset", {tx_flush, 15'b0, rx_flush}, 0);
    rst = 0;
    master_idle = 1;
    dma_req = 0;
    tick();
  endtask

  task automatic t_status();
    master_idle = 0;
    dma_req = 1;
    tick();
    chk(reg_rdata[31:30] == 2'b01, "R2 status low idle/dma", 32'(reg_rdata[31:30]), 1);
    master_idle = 1;
    dma_req = 0;
    tick();
    chk(reg_rdata[31:30] == 2'b10, "R2 status idle", 32'(reg_rdata[31:30]), 2);
  endtask

  task automatic t_flush(input logic [4:0] s, input logic [15:0] m, input string tag);
    wr_reg(txcmd(s));
    tick();
    chk(tx_flush == m, {tag, " pulse"}, 32'(tx_flush), 32'(m));
    chk(reg_rdata[5] == 1, "R4 request set", 32'(reg_rdata[5]), 1);
    tick();
    chk(tx_flush == 0, "R5 pulse one cycle", 32'(tx_flush), 0);
    tick();
    chk(reg_rdata[5] == 0, "R10 request cleared", 32'(reg_rdata[5]), 0);
    chk(reg_rdata[10:6] == s, "R4 selector readback", 32'(reg_rdata[10:6]), 32'(s));
  endtask

  task automatic t_write_zero();
    wr_reg(32'(5'd2) << 6);
    tick();
    chk(tx_flush == 0, "R4 write zero no flush", 32'(tx_flush), 0);
    tick();
    chk(tx_flush == 0 && reg_rdata[5] == 0, "R4 write zero no request",
        32'(reg_rdata[5]), 0);
    chk(reg_rdata[10:6] == 2, "R4 selector taken when idle", 32'(reg_rdata[10:6]), 2);
  endtask

  task automatic t_defer_lock();
    tx_busy = 16'h0010;
    wr_reg(txcmd(5'd4));
    wr_reg(32'(5'd9) << 6);
    tick();
    chk(tx_flush == 0, "R8 deferred while busy", 32'(tx_flush), 0);
    chk(reg_rdata[10:6] == 4, "R9 selector locked", 32'(reg_rdata[10:6]), 4);
    chk(reg_rdata[5] == 1, "R8 request held", 32'(reg_rdata[5]), 1);
    tx_busy = 16'h0100;
    tick();
    chk(tx_flush == 16'h0010, "R8 flush after busy drops", 32'(tx_flush), 32'h10);
    tick(); tick();
    chk(reg_rdata[5] == 0, "R10 cleared after deferred flush", 32'(reg_rdata[5]), 0);
    tx_busy = 0;
  endtask

  task automatic t_all_defer();
    tx_busy = 16'h8000;
    wr_reg(txcmd(5'b10000));
    tick(); tick();
    chk(tx_flush == 0, "R8 all-code waits for every busy", 32'(tx_flush), 0);
    tx_busy = 0;
    tick();
    chk(tx_flush == 16'hFFFF, "R6 all FIFOs pulsed", 32'(tx_flush), 32'hFFFF);
    tick(); tick();
    chk(reg_rdata[5] == 0, "R10 all-code cleared", 32'(reg_rdata[5]), 0);
  endtask

  task automatic t_bad_code();
    wr_reg(32'hFFFF_FFEF);
    tick();
    chk(tx_flush == 0, "R11 invalid code no pulse", 32'(tx_flush), 0);
    chk((reg_rdata & 32'h3FFF_F80F) == 0, "R3 reserved bits zero",
        reg_rdata & 32'h3FFF_F80F, 0);
    tick();
    chk(tx_flush == 0, "R11 still no pulse", 32'(tx_flush), 0);
    tick();
    chk(reg_rdata[5] == 0, "R11 request cleared", 32'(reg_rdata[5]), 0);
    chk(reg_rdata[10:6] == 5'd31, "R11 selector readback", 32'(reg_rdata[10:6]), 31);
  endtask

  task automatic t_rx();
    rx_busy = 1;
    wr_reg(32'h10);
    tick();
    chk(rx_flush == 0, "R12 rx deferred", 32'(rx_flush), 0);
    chk(reg_rdata[4] == 1, "R12 rx request set", 32'(reg_rdata[4]), 1);
    rx_busy = 0;
    tick();
    chk(rx_flush == 1, "R12 rx pulse", 32'(rx_flush), 1);
    tick();
    chk(rx_flush == 0, "R12 rx pulse one cycle", 32'(rx_flush), 0);
    tick();
    chk(reg_rdata[4] == 0, "R12 rx request cleared", 32'(reg_rdata[4]), 0);
    chk(tx_flush == 0, "R12 rx leaves tx alone", 32'(tx_flush), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_status();
    t_write_zero();
    host_mode = 0;
    t_flush(5'd0,  16'h0001, "R5 device fifo 0");
    t_flush(5'd9,  16'h0200, "R5 device fifo 9");
    t_flush(5'd15, 16'h8000, "R5 device fifo 15");
    t_flush(5'b10000, 16'hFFFF, "R6 all code");
    host_mode = 1;
    t_flush(5'd0, 16'h0001, "R7 host non-periodic");
    t_flush(5'd1, 16'h0002, "R7 host periodic");
    t_flush(5'd7, 16'h0000, "R7 host out of range");
    host_mode = 0;
    t_defer_lock();
    t_all_defer();
    t_bad_code();
    t_rx();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule